// File: doc/BRIEF.md
# Network Controller Command/Status Register

This block is the 16-bit command and status word of a DMA-driven network controller. The host uses it to issue start, stop and initialize commands and to ask for an immediate transmit-descriptor poll. It also reads back whether the receive and transmit paths are running, whether an interrupt is pending, and whether the interrupt pin is enabled. The command bits can only be set by the host. Writing a 0 to a command bit does nothing, and fixed precedence rules decide what happens when several commands arrive in one write. Stop beats start and initialize, and initialization is carried out before the data paths go live.

A buffer-management engine sits beside the register and answers it with single-cycle pulses: initialization block loaded, transmit descriptor fetched, and transmit underflow. The receive-disable, transmit-disable and keep-transmit-on-underflow controls come from neighbouring registers. The interrupt sources arrive already masked. The block drives an initialization request, a descriptor-poll request, a registered active-low interrupt pin and the readback word.

Top module: `ncsr_top`

## Requirements
- R1: Readback bit positions: bit 0 INIT, bit 1 START, bit 2 STOP, bit 3 TDEMAND, bit 4 TXRUN, bit 5 RXRUN, bit 6 IRQEN, bit 7 IRQFLAG. All higher bits read 0. After reset the word reads 0x0004 (only STOP set).
- R2: A write with bit 2 set forces STOP to 1 and START and INIT to 0, even if bits 0 and 1 are also set in that write.
- R3: Writing 0 to STOP, START, INIT or TDEMAND leaves them unchanged.
- R4: Writing 1 to START or INIT clears STOP. Setting STOP clears START, INIT, RXRUN, TXRUN, TDEMAND and IRQEN.
- R5: A START write without INIT, and with no initialization pending, sets RXRUN to NOT rx_disable and TXRUN to NOT tx_disable on the next clock edge.
- R6: When INIT is written, init_req rises on the next edge and stays high until an init_done pulse. If START is also set, RXRUN and TXRUN turn on only at that init_done pulse. INIT alone never turns them on.
- R7: A tx_underflow pulse clears TXRUN when uflo_keep is 0, and leaves it unchanged when uflo_keep is 1.
- R8: Writing 1 to bit 3 sets TDEMAND only while TXRUN is 1. A desc_fetched pulse clears it, and a fetch in the same cycle as the write wins. TDEMAND is forced to 0 whenever TXRUN is 0. poll_req equals TDEMAND AND TXRUN.
- R9: Bit 6 of every write loads IRQEN. irq_n is low one cycle after IRQEN and IRQFLAG are both 1, and is high otherwise.
- R10: IRQFLAG is the OR of all irq_src bits, reflected in the readback without delay, and is read-only.
- R11: An active soft_rst has the same effect as the hard reset rst_n.
- R12: Setting STOP while an initialization is pending drops init_req on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hard reset |
| soft_rst | input | 1 | Synchronous active-high soft reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | DATA_W | Host write data |
| rx_disable | input | 1 | Keeps the receive path off at start |
| tx_disable | input | 1 | Keeps the transmit path off at start |
| uflo_keep | input | 1 | 1: transmit stays on after an underflow |
| init_done | input | 1 | Pulse: initialization block loaded |
| desc_fetched | input | 1 | Pulse: transmit descriptor fetched |
| tx_underflow | input | 1 | Pulse: transmit underflow |
| irq_src | input | SRC_W | Masked interrupt sources |
| init_req | output | 1 | Initialization request to the engine |
| poll_req | output | 1 | Immediate descriptor-poll request |
| irq_n | output | 1 | Registered active-low interrupt |
| rd_data | output | DATA_W | Readback word |

## Verification
The bench builds the block with DATA_W at its default of 16 and SRC_W reduced to 4. With only four sources, each one can be raised alone and also all together, which covers every OR input of the interrupt flag. The 16-bit width covers the check that the upper readback byte stays 0. Directed scenarios cover the following cases:
- all three commands in one write;
- initialize-then-start, with the init_done pulse delayed;
- a stop that cancels a pending initialization;
- a descriptor fetch that collides with a demand write;
- underflow with each setting of uflo_keep.

// File: rtl/ncsr_pkg.sv
// Shared bit positions and widths for the command/status register.
// Assumes the readback word is wider than eight bits.
package ncsr_pkg;
    localparam int B_INIT  = 0;
    localparam int B_START = 1;
    localparam int B_STOP  = 2;
    localparam int B_TDMND = 3;
    localparam int B_TXRUN = 4;
    localparam int B_RXRUN = 5;
    localparam int B_IRQEN = 6;
    localparam int B_IRQFL = 7;
    localparam int USED_W  = 8;
endpackage

// File: rtl/ncsr_cmd.sv
// Command bits STOP/START/INIT, the pending-initialization flag and the
// run trigger for the data paths. Assumes init_done is a one-cycle pulse.
module ncsr_cmd (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic wr_en,
    input  logic wr_init,
    input  logic wr_start,
    input  logic wr_stop,
    input  logic init_done,
    output logic stop_q,
    output logic start_q,
    output logic init_q,
    output logic init_pend,
    output logic set_stop,
    output logic start_go
);
    logic clr, set_start, set_init;

    // Decode the write, stop overriding the other commands.
    always_comb begin
        clr       = !rst_n || soft_rst;
        set_stop  = wr_en && wr_stop;
        set_start = wr_en && wr_start && !set_stop;
        set_init  = wr_en && wr_init && !set_stop;
        start_go  = (set_start && !set_init && !init_pend) ||
                    (init_done && init_pend && !set_stop && !set_init &&
                     (start_q || set_start));
    end

    // Command bit state.
    always_ff @(posedge clk) begin
        if (clr) begin
            stop_q  <= 1'b1;
            start_q <= 1'b0;
            init_q  <= 1'b0;
        end else if (set_stop) begin
            stop_q  <= 1'b1;
            start_q <= 1'b0;
            init_q  <= 1'b0;
        end else begin
            if (set_start || set_init) stop_q <= 1'b0;
            if (set_start) start_q <= 1'b1;
            if (set_init)  init_q  <= 1'b1;
        end
    end

    // Pending initialization: raised by INIT, dropped by completion or stop.
    always_ff @(posedge clk) begin
        if (clr || set_stop)  init_pend <= 1'b0;
        else if (set_init)    init_pend <= 1'b1;
        else if (init_done)   init_pend <= 1'b0;
    end

    a_r2_stop_wins: assert property (@(posedge clk) disable iff (clr)
        (wr_en && wr_stop) |=> (stop_q && !start_q && !init_q));
    a_r3_zero_ignored: assert property (@(posedge clk) disable iff (clr)
        (wr_en && !wr_stop && !wr_start && !wr_init) |=>
        $stable({stop_q, start_q, init_q}));
    a_r12_stop_cancels: assert property (@(posedge clk) disable iff (clr)
        (wr_en && wr_stop) |=> !init_pend);
endmodule

// File: rtl/ncsr_run.sv
// Receive/transmit running status. Assumes start_go and set_stop are
// never both high (the command decoder guarantees it).
module ncsr_run (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic set_stop,
    input  logic start_go,
    input  logic init_pend,
    input  logic init_done,
    input  logic rx_disable,
    input  logic tx_disable,
    input  logic uflo_keep,
    input  logic tx_underflow,
    output logic rx_run,
    output logic tx_run
);
    logic clr;
    assign clr = !rst_n || soft_rst;

    // Receive path state.
    always_ff @(posedge clk) begin
        if (clr || set_stop) rx_run <= 1'b0;
        else if (start_go)   rx_run <= !rx_disable;
    end

    // Transmit path state, with drop on underflow.
    always_ff @(posedge clk) begin
        if (clr || set_stop)                  tx_run <= 1'b0;
        else if (start_go)                    tx_run <= !tx_disable;
        else if (tx_underflow && !uflo_keep)  tx_run <= 1'b0;
    end

    a_r6_wait_for_init: assert property (@(posedge clk) disable iff (clr)
        (init_pend && !init_done) |=> !$rose(rx_run) && !$rose(tx_run));
    a_r7_uflo_drop: assert property (@(posedge clk) disable iff (clr)
        (tx_underflow && !uflo_keep && !start_go) |=> !tx_run);
endmodule

// File: rtl/ncsr_poll.sv
// Transmit-demand bit and poll request. An engine fetch beats a host write
// in the same cycle; the bit is forced low while transmit is off.
module ncsr_poll (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic set_stop,
    input  logic tx_run,
    input  logic wr_tdmd,
    input  logic desc_fetched,
    output logic tdmd_q,
    output logic poll_req
);
    logic clr;
    assign clr = !rst_n || soft_rst;

    // Demand bit update.
    always_ff @(posedge clk) begin
        if (clr || set_stop || !tx_run) tdmd_q <= 1'b0;
        else if (desc_fetched)          tdmd_q <= 1'b0;
        else if (wr_tdmd)               tdmd_q <= 1'b1;
    end

    // Request only while transmit is running.
    assign poll_req = tdmd_q && tx_run;

    a_r8_off_clears: assert property (@(posedge clk) disable iff (clr)
        !tx_run |=> !tdmd_q);
    a_r8_fetch_wins: assert property (@(posedge clk) disable iff (clr)
        desc_fetched |=> !tdmd_q);
endmodule

// File: rtl/ncsr_irq.sv
// Interrupt enable, summary flag and registered active-low interrupt pin.
// Assumes irq_src is already masked.
module ncsr_irq #(
    parameter int SRC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             set_stop,
    input  logic             wr_en,
    input  logic             wr_ien,
    input  logic [SRC_W-1:0] irq_src,
    output logic             ien_q,
    output logic             flag,
    output logic             irq_n
);
    logic clr;
    assign clr  = !rst_n || soft_rst;
    assign flag = |irq_src;

    // Enable bit: loaded by every write, cleared by stop.
    always_ff @(posedge clk) begin
        if (clr || set_stop) ien_q <= 1'b0;
        else if (wr_en)      ien_q <= wr_ien;
    end

    // Registered interrupt pin.
    always_ff @(posedge clk) begin
        if (clr) irq_n <= 1'b1;
        else     irq_n <= !(ien_q && flag);
    end

    a_r9_no_irq_disabled: assert property (@(posedge clk) disable iff (clr)
        !ien_q |=> irq_n);
    a_r10_flag_is_or: assert property (@(posedge clk) disable iff (clr)
        (irq_src == '0) |-> !flag);
endmodule

// File: rtl/ncsr_top.sv
// Command/status register top: write decode, sub-block wiring, readback.
// Assumes DATA_W > 8; upper bits are unimplemented and read 0.
module ncsr_top #(
    parameter int DATA_W = 16,
    parameter int SRC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rx_disable,
    input  logic              tx_disable,
    input  logic              uflo_keep,
    input  logic              init_done,
    input  logic              desc_fetched,
    input  logic              tx_underflow,
    input  logic [SRC_W-1:0]  irq_src,
    output logic              init_req,
    output logic              poll_req,
    output logic              irq_n,
    output logic [DATA_W-1:0] rd_data
);
    import ncsr_pkg::*;

    localparam int HI_W = DATA_W - USED_W;

    logic stop_q, start_q, init_q, init_pend, set_stop, start_go;
    logic rx_run, tx_run, tdmd_q, ien_q, flag;
    logic unused_hi;

    assign unused_hi = ^wr_data[DATA_W-1:USED_W];

    ncsr_cmd u_cmd (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
        .wr_init(wr_data[B_INIT]), .wr_start(wr_data[B_START]),
        .wr_stop(wr_data[B_STOP]), .init_done(init_done),
        .stop_q(stop_q), .start_q(start_q), .init_q(init_q),
        .init_pend(init_pend), .set_stop(set_stop), .start_go(start_go)
    );

    ncsr_run u_run (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .set_stop(set_stop),
        .start_go(start_go), .init_pend(init_pend), .init_done(init_done),
        .rx_disable(rx_disable), .tx_disable(tx_disable),
        .uflo_keep(uflo_keep), .tx_underflow(tx_underflow),
        .rx_run(rx_run), .tx_run(tx_run)
    );

    ncsr_poll u_poll (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .set_stop(set_stop),
        .tx_run(tx_run), .wr_tdmd(wr_en && wr_data[B_TDMND]),
        .desc_fetched(desc_fetched), .tdmd_q(tdmd_q), .poll_req(poll_req)
    );

    ncsr_irq #(.SRC_W(SRC_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .set_stop(set_stop),
        .wr_en(wr_en), .wr_ien(wr_data[B_IRQEN]), .irq_src(irq_src),
        .ien_q(ien_q), .flag(flag), .irq_n(irq_n)
    );

    assign init_req = init_pend;

    // Assemble the readback word.
    always_comb begin
        rd_data          = '0;
        rd_data[B_INIT]  = init_q;
        rd_data[B_START] = start_q;
        rd_data[B_STOP]  = stop_q;
        rd_data[B_TDMND] = tdmd_q;
        rd_data[B_TXRUN] = tx_run;
        rd_data[B_RXRUN] = rx_run;
        rd_data[B_IRQEN] = ien_q;
        rd_data[B_IRQFL] = flag;
    end

    a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:USED_W] == HI_W'(0));
    a_r4_stop_excl: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        stop_q |-> !(start_q || init_q || rx_run || tx_run));
endmodule

// File: tb/ncsr_top_test.sv
module ncsr_top_test;
    localparam int DW = 16;
    localparam int SW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0, soft_rst = 1'b0, wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic rx_disable = 1'b0, tx_disable = 1'b0, uflo_keep = 1'b0;
    logic init_done = 1'b0, desc_fetched = 1'b0, tx_underflow = 1'b0;
    logic [SW-1:0] irq_src = '0;
    logic init_req, poll_req, irq_n;
    logic [DW-1:0] rd_data;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    ncsr_top #(.DATA_W(DW), .SRC_W(SW)) uut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
        .wr_data(wr_data), .rx_disable(rx_disable), .tx_disable(tx_disable),
        .uflo_keep(uflo_keep), .init_done(init_done),
        .desc_fetched(desc_fetched), .tx_underflow(tx_underflow),
        .irq_src(irq_src), .init_req(init_req), .poll_req(poll_req),
        .irq_n(irq_n), .rd_data(rd_data)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [DW-1:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1;
        @(negedge clk);
        s = 1'b0;
    endtask

    task automatic hard_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        hard_reset();
        chk("R1 reset word", rd_data, 16'h0004);
        chk("R1 reset init_req", init_req, 0);
        chk("R1 reset irq_n", irq_n, 1);
        chk("R1 reset poll", poll_req, 0);
    endtask

    task automatic t_start();
        wr(16'h0002);
        chk("R5 start both run", rd_data, 16'h0032);
        chk("R4 start cleared stop", rd_data[2], 0);
        wr(16'h0000);
        chk("R3 write zero ignored", rd_data, 16'h0032);
        wr(16'h0004);
        chk("R4 stop clears run", rd_data, 16'h0004);
        rx_disable = 1'b1;
        wr(16'h0002);
        chk("R5 rx disabled", rd_data, 16'h0012);
        wr(16'h0004);
        rx_disable = 1'b0; tx_disable = 1'b1;
        wr(16'h0002);
        chk("R5 tx disabled", rd_data, 16'h0022);
        wr(16'h0004);
        tx_disable = 1'b0;
    endtask

    task automatic t_stop_wins();
        wr(16'h0007);
        chk("R2 stop over start/init", rd_data, 16'h0004);
        chk("R2 no init_req", init_req, 0);
    endtask

    task automatic t_init_start();
        wr(16'h0003);
        chk("R6 init+start no run yet", rd_data, 16'h0003);
        chk("R6 init_req high", init_req, 1);
        repeat (5) @(negedge clk);
        chk("R6 still waiting", rd_data, 16'h0003);
        pulse(init_done);
        chk("R6 run after init_done", rd_data, 16'h0033);
        chk("R6 init_req dropped", init_req, 0);
        wr(16'h0004);
        wr(16'h0001);
        pulse(init_done);
        chk("R6 init alone no run", rd_data, 16'h0001);
        wr(16'h0002);
        chk("R6 later start runs", rd_data, 16'h0033);
        wr(16'h0004);
    endtask

    task automatic t_stop_cancel();
        wr(16'h0001);
        chk("R12 init_req set", init_req, 1);
        wr(16'h0004);
        chk("R12 stop cancels init_req", init_req, 0);
        pulse(init_done);
        chk("R12 late done no effect", rd_data, 16'h0004);
    endtask

    task automatic t_underflow();
        wr(16'h0002);
        uflo_keep = 1'b1;
        pulse(tx_underflow);
        chk("R7 keep on underflow", rd_data, 16'h0032);
        uflo_keep = 1'b0;
        pulse(tx_underflow);
        chk("R7 drop on underflow", rd_data, 16'h0022);
        wr(16'h0004);
    endtask

    task automatic t_demand();
        wr(16'h0008);
        chk("R8 demand ignored when off", rd_data, 16'h0004);
        chk("R8 no poll when off", poll_req, 0);
        wr(16'h0002);
        wr(16'h0008);
        chk("R8 demand set", rd_data, 16'h003A);
        chk("R8 poll_req", poll_req, 1);
        wr(16'h0000);
        chk("R3 zero keeps demand", rd_data[3], 1);
        pulse(desc_fetched);
        chk("R8 fetch clears", rd_data[3], 0);
        desc_fetched = 1'b1;
        wr(16'h0008);
        desc_fetched = 1'b0;
        chk("R8 fetch beats write", rd_data[3], 0);
        wr(16'h0008);
        pulse(tx_underflow);
        chk("R8 txrun off clears poll", poll_req, 0);
        @(negedge clk);
        chk("R8 demand forced low", rd_data[3], 0);
        wr(16'h0004);
    endtask

    task automatic t_irq();
        wr(16'h0040);
        chk("R9 irqen set", rd_data, 16'h0044);
        for (int i = 0; i < SW; i++) begin
            irq_src = SW'(1) << i;
            #1;
            chk("R10 flag per source", rd_data[7], 1);
            @(negedge clk);
            chk("R9 irq_n low", irq_n, 0);
        end
        irq_src = '0;
        #1;
        chk("R10 flag clears", rd_data[7], 0);
        @(negedge clk);
        chk("R9 irq_n high", irq_n, 1);
        wr(16'h0000);
        irq_src = '1;
        @(negedge clk);
        chk("R9 disabled irq_n", irq_n, 1);
        chk("R10 flag all", rd_data, 16'h0084);
        wr(16'h0080);
        chk("R10 flag read-only", rd_data, 16'h0084);
        wr(16'h0040);
        @(negedge clk);
        chk("R9 irq_n enabled", irq_n, 0);
        wr(16'h0004);
        chk("R4 stop clears irqen", rd_data[6], 0);
        @(negedge clk);
        chk("R9 irq_n after stop", irq_n, 1);
        irq_src = '0;
        wr(16'hFF00);
        chk("R1 upper bits zero", rd_data, 16'h0004);
    endtask

    task automatic t_soft();
        wr(16'h0042);
        wr(16'h0008);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        chk("R11 soft reset word", rd_data, 16'h0004);
        chk("R11 soft reset poll", poll_req, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_start();
        t_stop_wins();
        t_init_start();
        t_stop_cancel();
        t_underflow();
        t_demand();
        t_irq();
        t_soft();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual hang expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule